// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block stores the working registers of a 32-bit load-store processor core. Software always sees sixteen architectural registers, indexed 0 to 15. Index 13 is the stack pointer, 14 is the link register and 15 is the program counter. The current processor mode arrives on a 5-bit input. For some indices the mode selects a private physical copy in place of the shared one, so an exception handler can use its own stack pointer and link register without saving the interrupted ones. The fast-interrupt mode has a larger private set, covering indices 8 through 14.

The block has two combinational read ports and one write port. Each port is addressed by an architectural index, taken together with the current mode. The program counter sits in its own register with a dedicated incrementer, so a fetch stage can advance it every cycle without the ALU. Each of the five exception modes also has one saved status register, reached through its own read and write pins.

All ports are plain control and data pins. Every access completes in one cycle and no port ever stalls, so there is no valid/ready handshake and no back-pressure. A write takes effect at the rising clock edge. A read reflects the contents of the storage before that edge.

Top module: `banked_regfile`

## Requirements
- R1: After reset every general register and every saved status register reads zero, and the program counter reads RESET_PC.
- R2: Indices 0 to 7 name one shared physical register each in every mode.
- R3: In fast-interrupt mode (mode 5'b10001), indices 8 to 14 reach private copies. Those copies are separate from the user copies of the same indices.
- R4: The interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have private copies of indices 13 and 14 only. In these modes, indices 8 to 12 reach the user copies.
- R5: System mode (5'b11111) uses exactly the same registers as user mode (5'b10000).
- R6: Index 15 on either read port returns the program counter. A write to index 15 loads the program counter at the next edge.
- R7: While pc_inc is high, the program counter grows by PC_STEP at each edge. A write to index 15 in the same cycle takes priority over the increment.
- R8: When a read port addresses the register being written in the same cycle, it returns the old value. From the next cycle on it returns the new value.
- R9: Each exception mode owns one saved status register. A write to it through spsr_wr_en is visible on spsr_rd_data only while that mode is current.
- R10: In user or system mode, spsr_rd_data reads zero and a saved-status write changes no saved status register.
- R11: A mode encoding other than the seven listed is treated as user mode for the general registers.
- R12: The two read ports are independent, and both can return different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 5 | Current processor mode |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port architectural index |
| wr_data | input | DATA_W | Write port data |
| pc_inc | input | 1 | Advance program counter by PC_STEP |
| pc_out | output | DATA_W | Program counter value |
| spsr_wr_en | input | 1 | Saved status write enable for the current mode |
| spsr_wr_data | input | DATA_W | Saved status write data |
| spsr_rd_data | output | DATA_W | Saved status of the current mode |

## Verification
The bench keeps DATA_W at 32 and PC_STEP at 4. It sets RESET_PC to 64, so the reset value of the program counter can be told apart from the cleared general registers. With these values, the increment and load-priority cases of the program counter can be counted in exact byte steps. The same marker value is written in several modes, which exposes any mapping error between the shared copies and the private ones.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  localparam int ARCH_N  = 16;
  localparam int IDX_W   = $clog2(ARCH_N);
  localparam int PHYS_N  = 31;
  localparam int PHYS_W  = $clog2(PHYS_N);
  localparam int SAVED_N = 5;
  localparam int SAVED_W = $clog2(SAVED_N);
  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(ARCH_N - 1);

  typedef struct packed {
    logic               valid;
    logic [SAVED_W-1:0] slot;
  } saved_sel_t;

  // Physical layout: 0..14 user copies, 15 program counter (held apart),
  // 16..22 fast-interrupt 8..14, then pairs of 13/14 for irq, svc, abt, und.
  function automatic logic [PHYS_W-1:0] phys_of(input logic [4:0] m,
                                                 input logic [IDX_W-1:0] idx);
    logic [PHYS_W-1:0] wide;
    wide = {1'b0, idx};
    phys_of = wide;
    if (idx >= IDX_W'(8) && idx != PC_IDX) begin
      unique case (m)
        MODE_FIQ: phys_of = wide + PHYS_W'(8);
        MODE_IRQ: if (idx >= IDX_W'(13)) phys_of = wide + PHYS_W'(10);
        MODE_SVC: if (idx >= IDX_W'(13)) phys_of = wide + PHYS_W'(12);
        MODE_ABT: if (idx >= IDX_W'(13)) phys_of = wide + PHYS_W'(14);
        MODE_UND: if (idx >= IDX_W'(13)) phys_of = wide + PHYS_W'(16);
        default:  phys_of = wide;
      endcase
    end
  endfunction

  function automatic saved_sel_t saved_of(input logic [4:0] m);
    saved_of = '0;
    unique case (m)
      MODE_FIQ: saved_of = '{valid: 1'b1, slot: SAVED_W'(0)};
      MODE_IRQ: saved_of = '{valid: 1'b1, slot: SAVED_W'(1)};
      MODE_SVC: saved_of = '{valid: 1'b1, slot: SAVED_W'(2)};
      MODE_ABT: saved_of = '{valid: 1'b1, slot: SAVED_W'(3)};
      MODE_UND: saved_of = '{valid: 1'b1, slot: SAVED_W'(4)};
      default:  saved_of = '0;
    endcase
  endfunction

endpackage

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [PHYS_W-1:0]             waddr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [PHYS_N-1:0][DATA_W-1:0] regs
);

  for (genvar g = 0; g < PHYS_N; g++) begin : g_cell
    if (g == int'(PC_IDX)) begin : g_hole
      assign regs[g] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           q <= '0;
        else if (we && waddr == PHYS_W'(g))   q <= wdata;
      end
      assign regs[g] = q;
    end
  end

endmodule

// File: rtl/regbank_pc.sv
module regbank_pc #(
  parameter int              DATA_W   = 32,
  parameter int              PC_STEP  = 4,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              inc,
  output logic [DATA_W-1:0] pc
);

  localparam logic [DATA_W-1:0] STEP = DATA_W'(PC_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= RESET_PC;
    else if (load) pc <= load_data;
    else if (inc)  pc <= pc + STEP;
  end

endmodule

// File: rtl/regbank_saved.sv
module regbank_saved
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  saved_sel_t                       sel;
  logic [SAVED_N-1:0][DATA_W-1:0]   slots;

  assign sel = saved_of(mode);

  for (genvar s = 0; s < SAVED_N; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        slots[s] <= '0;
      else if (we && sel.valid && sel.slot == SAVED_W'(s)) slots[s] <= wdata;
    end
  end

  assign rdata = sel.valid ? slots[sel.slot] : '0;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                PC_STEP  = 4,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_inc,
  output logic [DATA_W-1:0] pc_out,
  input  logic              spsr_wr_en,
  input  logic [DATA_W-1:0] spsr_wr_data,
  output logic [DATA_W-1:0] spsr_rd_data
);

  localparam int RD_PORTS = 2;

  logic [PHYS_N-1:0][DATA_W-1:0] regs;
  logic [PHYS_W-1:0]             wr_phys;
  logic                          wr_is_pc;
  logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx;
  logic [RD_PORTS-1:0][DATA_W-1:0] rd_data;

  assign wr_is_pc = (wr_idx == PC_IDX);
  assign wr_phys  = phys_of(mode, wr_idx);

  regbank_store #(.DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en && !wr_is_pc),
    .waddr (wr_phys),
    .wdata (wr_data),
    .regs  (regs)
  );

  regbank_pc #(.DATA_W(DATA_W), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_en && wr_is_pc),
    .load_data (wr_data),
    .inc       (pc_inc),
    .pc        (pc_out)
  );

  regbank_saved #(.DATA_W(DATA_W)) u_saved (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .we    (spsr_wr_en),
    .wdata (spsr_wr_data),
    .rdata (spsr_rd_data)
  );

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [PHYS_W-1:0] phys;
    assign phys       = phys_of(mode, rd_idx[p]);
    assign rd_data[p] = (rd_idx[p] == PC_IDX) ? pc_out : regs[phys];
  end

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import regbank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              pc_inc,
  input logic [DATA_W-1:0] pc_out,
  input logic              spsr_wr_en,
  input logic [DATA_W-1:0] spsr_wr_data,
  input logic [DATA_W-1:0] spsr_rd_data
);

  logic pc_wr;
  logic exc_mode;
  assign pc_wr    = wr_en && (wr_idx == 4'd15);
  assign exc_mode = (mode == MODE_FIQ) || (mode == MODE_IRQ) || (mode == MODE_SVC) ||
                    (mode == MODE_ABT) || (mode == MODE_UND);

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !pc_wr) |=> pc_out == $past(pc_out) + DATA_W'(PC_STEP));

  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_inc && !pc_wr) |=> $stable(pc_out));

  // R6
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |=> pc_out == $past(wr_data));

  // R6
  pc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> rd_a_data == pc_out);

  // R8
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wr_idx) != 4'd15 && mode == $past(mode) &&
     rd_a_idx == $past(wr_idx)) |-> rd_a_data == $past(wr_data));

  // R10
  saved_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_USR || mode == MODE_SYS) |-> spsr_rd_data == '0);

  // R9
  saved_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spsr_wr_en) && exc_mode && mode == $past(mode)) |->
      spsr_rd_data == $past(spsr_wr_data));

endmodule

bind banked_regfile regbank_chk #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) u_regbank_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .rd_a_idx     (rd_a_idx),
  .rd_a_data    (rd_a_data),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .wr_data      (wr_data),
  .pc_inc       (pc_inc),
  .pc_out       (pc_out),
  .spsr_wr_en   (spsr_wr_en),
  .spsr_wr_data (spsr_wr_data),
  .spsr_rd_data (spsr_rd_data)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam logic [DW-1:0] RST_PC = 32'd64;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b00000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    mode = USR;
  logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0, pc_out;
  logic [DW-1:0] spsr_wr_data = '0, spsr_rd_data;
  logic          wr_en = 1'b0, pc_inc = 1'b0, spsr_wr_en = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile #(.DATA_W(DW), .PC_STEP(4), .RESET_PC(RST_PC)) i_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_inc(pc_inc), .pc_out(pc_out),
    .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data), .spsr_rd_data(spsr_rd_data)
  );

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] i, input logic [DW-1:0] d);
    @(negedge clk);
    mode = m; wr_idx = i; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_a(input logic [4:0] m, input logic [3:0] i, input string tag,
                      input logic [DW-1:0] exp);
    mode = m; rd_a_idx = i;
    #1;
    chk(tag, rd_a_data, exp);
  endtask

  task automatic spsr_wr(input logic [4:0] m, input logic [DW-1:0] d);
    @(negedge clk);
    mode = m; spsr_wr_data = d; spsr_wr_en = 1'b1;
    @(negedge clk);
    spsr_wr_en = 1'b0;
  endtask

  task automatic spsr_chk(input logic [4:0] m, input string tag, input logic [DW-1:0] exp);
    mode = m;
    #1;
    chk(tag, spsr_rd_data, exp);
  endtask

  task automatic t_reset;
    rd_a(USR, 4'd0, "R1 r0 after reset", '0);
    rd_a(FIQ, 4'd13, "R1 fiq r13 after reset", '0);
    rd_a(USR, 4'd15, "R1 pc after reset", RST_PC);
    chk("R1 pc_out after reset", pc_out, RST_PC);
    spsr_chk(SVC, "R1 svc saved after reset", '0);
  endtask

  task automatic t_shared_low;
    wr(USR, 4'd3, 32'hA5A5_0003);
    rd_a(FIQ, 4'd3, "R2 r3 from fiq", 32'hA5A5_0003);
    rd_a(SVC, 4'd3, "R2 r3 from svc", 32'hA5A5_0003);
    wr(UND, 4'd7, 32'h0000_7777);
    rd_a(USR, 4'd7, "R2 r7 written in und", 32'h0000_7777);
  endtask

  task automatic t_fiq;
    wr(USR, 4'd8, 32'h1);
    wr(USR, 4'd13, 32'h2);
    wr(FIQ, 4'd8, 32'h3);
    wr(FIQ, 4'd14, 32'h4);
    rd_a(USR, 4'd8, "R3 usr r8 kept", 32'h1);
    rd_a(USR, 4'd13, "R3 usr r13 kept", 32'h2);
    rd_a(FIQ, 4'd8, "R3 fiq r8", 32'h3);
    rd_a(FIQ, 4'd14, "R3 fiq r14", 32'h4);
    rd_a(FIQ, 4'd13, "R3 fiq r13 private", '0);
    rd_a(USR, 4'd14, "R3 usr r14 untouched", '0);
  endtask

  task automatic t_exc;
    wr(SVC, 4'd13, 32'h5);
    wr(IRQ, 4'd13, 32'h6);
    wr(ABT, 4'd14, 32'h7);
    wr(UND, 4'd13, 32'h8);
    rd_a(SVC, 4'd13, "R4 svc r13", 32'h5);
    rd_a(IRQ, 4'd13, "R4 irq r13", 32'h6);
    rd_a(ABT, 4'd14, "R4 abt r14", 32'h7);
    rd_a(UND, 4'd13, "R4 und r13", 32'h8);
    rd_a(ABT, 4'd13, "R4 abt r13 private", '0);
    rd_a(USR, 4'd13, "R4 usr r13 kept", 32'h2);
    rd_a(SVC, 4'd8, "R4 svc r8 shared", 32'h1);
    wr(IRQ, 4'd12, 32'hC);
    rd_a(USR, 4'd12, "R4 irq r12 shared", 32'hC);
  endtask

  task automatic t_sys;
    wr(SYS, 4'd13, 32'h9);
    rd_a(USR, 4'd13, "R5 sys r13 is usr", 32'h9);
    rd_a(SYS, 4'd8, "R5 sys r8 is usr", 32'h1);
  endtask

  task automatic t_unknown;
    wr(BAD, 4'd14, 32'hA);
    rd_a(USR, 4'd14, "R11 unknown mode r14", 32'hA);
    rd_a(BAD, 4'd13, "R11 unknown mode r13", 32'h9);
  endtask

  task automatic t_two_ports;
    mode = FIQ; rd_a_idx = 4'd3; rd_b_idx = 4'd8;
    #1;
    chk("R12 port a r3", rd_a_data, 32'hA5A5_0003);
    chk("R12 port b fiq r8", rd_b_data, 32'h3);
  endtask

  task automatic t_rdw;
    @(negedge clk);
    mode = USR; rd_a_idx = 4'd3; rd_b_idx = 4'd3;
    wr_idx = 4'd3; wr_data = 32'hDEAD_BEEF; wr_en = 1'b1;
    #1;
    chk("R8 port a old value", rd_a_data, 32'hA5A5_0003);
    chk("R8 port b old value", rd_b_data, 32'hA5A5_0003);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R8 port a new value", rd_a_data, 32'hDEAD_BEEF);
  endtask

  task automatic t_pc;
    wr(USR, 4'd15, 32'd100);
    rd_a(USR, 4'd15, "R6 r15 after write", 32'd100);
    mode = FIQ; rd_b_idx = 4'd15;
    #1;
    chk("R6 r15 on port b in fiq", rd_b_data, 32'd100);
    @(negedge clk);
    pc_inc = 1'b1;
    repeat (3) @(negedge clk);
    pc_inc = 1'b0;
    #1;
    chk("R7 pc after three steps", pc_out, 32'd112);
    @(negedge clk);
    #1;
    chk("R7 pc holds without inc", pc_out, 32'd112);
    @(negedge clk);
    pc_inc = 1'b1; mode = USR; wr_idx = 4'd15; wr_data = 32'd200; wr_en = 1'b1;
    @(negedge clk);
    pc_inc = 1'b0; wr_en = 1'b0;
    #1;
    chk("R7 write beats increment", pc_out, 32'd200);
  endtask

  task automatic t_saved;
    spsr_wr(FIQ, 32'hF1);
    spsr_wr(IRQ, 32'hF2);
    spsr_wr(SVC, 32'hF3);
    spsr_wr(ABT, 32'hF4);
    spsr_wr(UND, 32'hF5);
    spsr_chk(FIQ, "R9 fiq saved", 32'hF1);
    spsr_chk(IRQ, "R9 irq saved", 32'hF2);
    spsr_chk(SVC, "R9 svc saved", 32'hF3);
    spsr_chk(ABT, "R9 abt saved", 32'hF4);
    spsr_chk(UND, "R9 und saved", 32'hF5);
    spsr_wr(USR, 32'hBAD0);
    spsr_wr(SYS, 32'hBAD1);
    spsr_chk(USR, "R10 usr saved reads zero", '0);
    spsr_chk(SYS, "R10 sys saved reads zero", '0);
    spsr_chk(FIQ, "R10 fiq saved untouched", 32'hF1);
    spsr_chk(IRQ, "R10 irq saved untouched", 32'hF2);
    spsr_chk(SVC, "R10 svc saved untouched", 32'hF3);
    spsr_chk(ABT, "R10 abt saved untouched", 32'hF4);
    spsr_chk(UND, "R10 und saved untouched", 32'hF5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shared_low();
    t_fiq();
    t_exc();
    t_sys();
    t_unknown();
    t_two_ports();
    t_rdw();
    t_pc();
    t_saved();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule